// File: doc/BRIEF.md
# Flash-Card Host Register Block

This block is the software-facing register file of a simplified flash-card host. It decodes a 32-bit memory-mapped bus. Software programs a buffer address, a command argument, a block length and a block count, then writes a command word. The low six bits of that word select a canned responder. The responder answers most commands locally: it fills four response words and raises an end-of-command flag. Read and write commands also start a transfer request toward a neighbouring data-mover block, and they finish only when that block pulses a done input.

Interrupt status is kept in a small sticky register. A separate enable mask gates it, and one level interrupt output is the registered OR of status AND enable. The card-state word reports that a card is present and whether it is write-protected, the latter taken from an input pin.

Top module: `card_host_regs`

## Requirements
- R1: Offsets decode as status 0x00, enable 0x04, buffer 0x08, command 0x0C, argument 0x10, response words 0x14/0x18/0x1C/0x20 (word 0 to 3), block length 0x24, block count 0x28, state 0x2C. Only status, the four response words and state are readable. Every other offset, including the write-only registers and any unmapped offset, reads as zero, and writes to unmapped offsets change nothing.
- R2: A read of the status offset returns status AND enable. Status bit 0 is end-of-command, bit 1 is end-of-data and bit 2 is state-change.
- R3: A write to the status offset clears exactly the status bits written as 1.
- R4: A write to the enable offset loads the low three bits as the mask and clears every status bit.
- R5: `irq` is the OR of (status AND enable) as held in the previous cycle, and it is low out of reset.
- R6: Writes to block length and block count store the written value plus one, visible on `xfer_blk_len` and `xfer_blk_cnt`.
- R7: A command uses bits 5:0 of the written word as opcode. Response words 1 to 3 become zero and word 0 takes the canned value. A command that is not a transfer sets end-of-command in the cycle after the write.
- R8: Canned word 0 is state<<9 | 1<<8 (ready-for-data): opcode 7 gives state 3 (0x700), opcode 12 gives state 5 (0xB00), and opcodes 13, 16, 17, 18, 24 and 25 give state 4 (0x900). Every other opcode gives 0.
- R9: Opcode 16 loads the block length from the argument register unchanged (no plus one).
- R10: Opcodes 17, 18, 24 and 25 raise `xfer_req`. Opcodes 17 and 24 first force the block count to 1, while 18 and 25 keep the programmed count. `xfer_write` is 1 for 24 and 25. `xfer_offset` carries the argument. A `xfer_done` pulse while the request is up drops it and sets end-of-command and end-of-data together.
- R11: While `xfer_req` is high, command writes are ignored: the responses, the status and the request stay as they are.
- R12: The state offset reads bit 0 = 1 (card present) and bit 1 = `card_ro`, and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| card_ro | input | 1 | Card write-protect level |
| irq | output | 1 | Level interrupt |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_write | output | 1 | 1 = host-to-card transfer |
| xfer_buf | output | 32 | Buffer address |
| xfer_offset | output | 32 | Card offset (argument at command time) |
| xfer_blk_len | output | 32 | Block length |
| xfer_blk_cnt | output | 32 | Block count |
| xfer_done | input | 1 | Transfer completion pulse |

## Verification
The bench sweeps all 64 opcodes with junk in the upper command bits, so a design that decodes more than six bits, or that maps a neighbouring opcode onto a canned answer, returns a wrong word 0. For each transfer it also fires a second command while busy: a design that does not block it would overwrite the response or set end-of-command early. The partial write-one-to-clear and the clear-on-enable cases are aimed at a status register that clears every bit or keeps stale flags. The one-cycle `irq` lag and the masked status read catch an unregistered or unmasked interrupt. The length and count plus-one, together with the unadjusted set-length command, catch an off-by-one in either path.

// File: rtl/card_host_pkg.sv
// Shared constants for the card host register block: register offsets,
// status bit positions, opcodes and the short-response builder.
package card_host_pkg;
    localparam int REG_W  = 32;
    localparam int STAT_W = 3;
    localparam int OPC_W  = 6;

    localparam logic [7:0] OFF_STATUS = 8'h00;
    localparam logic [7:0] OFF_ENABLE = 8'h04;
    localparam logic [7:0] OFF_BUF    = 8'h08;
    localparam logic [7:0] OFF_CMD    = 8'h0C;
    localparam logic [7:0] OFF_ARG    = 8'h10;
    localparam logic [7:0] OFF_RESP0  = 8'h14;
    localparam logic [7:0] OFF_RESP1  = 8'h18;
    localparam logic [7:0] OFF_RESP2  = 8'h1C;
    localparam logic [7:0] OFF_RESP3  = 8'h20;
    localparam logic [7:0] OFF_LEN    = 8'h24;
    localparam logic [7:0] OFF_CNT    = 8'h28;
    localparam logic [7:0] OFF_STATE  = 8'h2C;

    localparam int ST_EOC = 0;
    localparam int ST_EOD = 1;

    localparam logic [OPC_W-1:0] OPC_SELECT   = 6'd7;
    localparam logic [OPC_W-1:0] OPC_STOP     = 6'd12;
    localparam logic [OPC_W-1:0] OPC_STATUS   = 6'd13;
    localparam logic [OPC_W-1:0] OPC_SETLEN   = 6'd16;
    localparam logic [OPC_W-1:0] OPC_RD_ONE   = 6'd17;
    localparam logic [OPC_W-1:0] OPC_RD_MANY  = 6'd18;
    localparam logic [OPC_W-1:0] OPC_WR_ONE   = 6'd24;
    localparam logic [OPC_W-1:0] OPC_WR_MANY  = 6'd25;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_STATUS, SEL_ENABLE, SEL_BUF, SEL_CMD, SEL_ARG,
        SEL_RESP0, SEL_RESP1, SEL_RESP2, SEL_RESP3, SEL_LEN, SEL_CNT, SEL_STATE
    } reg_sel_e;

    // Short response: current state in bits 12:9, ready-for-data in bit 8.
    function automatic logic [REG_W-1:0] short_resp(input logic [3:0] st);
        return {19'd0, st, 1'b1, 8'd0};
    endfunction
endpackage

// File: rtl/chr_addr_decode.sv
// Address decoder: maps a byte offset to a register select.
// Assumes ADDR_W >= 8; any offset not listed maps to SEL_NONE.
module chr_addr_decode
    import card_host_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    // Full compare of the offset against each register location.
    always_comb begin
        case (addr)
            ADDR_W'(OFF_STATUS): sel = SEL_STATUS;
            ADDR_W'(OFF_ENABLE): sel = SEL_ENABLE;
            ADDR_W'(OFF_BUF):    sel = SEL_BUF;
            ADDR_W'(OFF_CMD):    sel = SEL_CMD;
            ADDR_W'(OFF_ARG):    sel = SEL_ARG;
            ADDR_W'(OFF_RESP0):  sel = SEL_RESP0;
            ADDR_W'(OFF_RESP1):  sel = SEL_RESP1;
            ADDR_W'(OFF_RESP2):  sel = SEL_RESP2;
            ADDR_W'(OFF_RESP3):  sel = SEL_RESP3;
            ADDR_W'(OFF_LEN):    sel = SEL_LEN;
            ADDR_W'(OFF_CNT):    sel = SEL_CNT;
            ADDR_W'(OFF_STATE):  sel = SEL_STATE;
            default:             sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/chr_cmd_responder.sv
// Canned command responder: classifies an opcode and produces response
// word 0 plus the side-effect flags. Purely combinational; the caller
// registers the results when the command is accepted.
module chr_cmd_responder
    import card_host_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output logic [REG_W-1:0] resp0,
    output logic             is_data,
    output logic             force_single,
    output logic             is_write,
    output logic             load_len
);
    // Opcode table for the small set of answered commands.
    always_comb begin
        resp0        = '0;
        is_data      = 1'b0;
        force_single = 1'b0;
        is_write     = 1'b0;
        load_len     = 1'b0;
        case (opc)
            OPC_SELECT:  resp0 = short_resp(4'd3);
            OPC_STOP:    resp0 = short_resp(4'd5);
            OPC_STATUS:  resp0 = short_resp(4'd4);
            OPC_SETLEN: begin
                resp0    = short_resp(4'd4);
                load_len = 1'b1;
            end
            OPC_RD_ONE, OPC_RD_MANY, OPC_WR_ONE, OPC_WR_MANY: begin
                resp0        = short_resp(4'd4);
                is_data      = 1'b1;
                force_single = (opc == OPC_RD_ONE) || (opc == OPC_WR_ONE);
                is_write     = (opc == OPC_WR_ONE) || (opc == OPC_WR_MANY);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/chr_irq_status.sv
// Sticky interrupt status with enable mask and registered level interrupt.
// Assumes set requests win over clears arriving in the same cycle.
module chr_irq_status #(
    parameter int STAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [STAT_W-1:0] en_data,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_data,
    input  logic [STAT_W-1:0] set_vec,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] en_q,
    output logic              irq
);
    // Status bits: cleared by enable write or write-one-to-clear, set by events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (en_wr) begin
            stat_q <= set_vec;
        end else if (clr_wr) begin
            stat_q <= (stat_q & ~clr_data) | set_vec;
        end else begin
            stat_q <= stat_q | set_vec;
        end
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_data;
    end

    // Registered interrupt level from the current masked status.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(stat_q & en_q);
    end
endmodule

// File: rtl/card_host_regs.sv
// Card host register block top: bus decode, configuration registers,
// response words, transfer handshake and read mux.
// Assumes single-cycle write strobes and a combinational read port;
// xfer_done is only honoured while xfer_req is high.
module card_host_regs
    import card_host_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              card_ro,
    output logic              irq,
    output logic              xfer_req,
    output logic              xfer_write,
    output logic [REG_W-1:0]  xfer_buf,
    output logic [REG_W-1:0]  xfer_offset,
    output logic [REG_W-1:0]  xfer_blk_len,
    output logic [REG_W-1:0]  xfer_blk_cnt,
    input  logic              xfer_done
);
    localparam int RESP_N = 4;

    reg_sel_e          sel;
    logic [REG_W-1:0]  resp0_c;
    logic              is_data, force_single, is_write, load_len;
    logic              cmd_go, finish;
    logic [STAT_W-1:0] set_vec, stat_q, en_q;
    logic [REG_W-1:0]  arg_q;
    logic [REG_W-1:0]  resp_q [RESP_N];

    chr_addr_decode #(.ADDR_W(ADDR_W)) dec_i (.addr(bus_addr), .sel(sel));

    chr_cmd_responder rsp_i (
        .opc(bus_wdata[OPC_W-1:0]), .resp0(resp0_c), .is_data(is_data),
        .force_single(force_single), .is_write(is_write), .load_len(load_len)
    );

    // A command is accepted only when no transfer is outstanding.
    assign cmd_go = bus_wr && (sel == SEL_CMD) && !xfer_req;
    assign finish = xfer_req && xfer_done;

    // Event bits fed into the status register.
    always_comb begin
        set_vec = '0;
        if (cmd_go && !is_data) set_vec[ST_EOC] = 1'b1;
        if (finish) begin
            set_vec[ST_EOC] = 1'b1;
            set_vec[ST_EOD] = 1'b1;
        end
    end

    chr_irq_status #(.STAT_W(STAT_W)) st_i (
        .clk(clk), .rst_n(rst_n),
        .en_wr(bus_wr && (sel == SEL_ENABLE)), .en_data(bus_wdata[STAT_W-1:0]),
        .clr_wr(bus_wr && (sel == SEL_STATUS)), .clr_data(bus_wdata[STAT_W-1:0]),
        .set_vec(set_vec), .stat_q(stat_q), .en_q(en_q), .irq(irq)
    );

    // Plain software-loaded registers: buffer address and argument.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_buf <= '0;
            arg_q    <= '0;
        end else if (bus_wr) begin
            if (sel == SEL_BUF) xfer_buf <= bus_wdata;
            if (sel == SEL_ARG) arg_q    <= bus_wdata;
        end
    end

    // Block length: plus-one on software write, raw argument on set-length.
    always_ff @(posedge clk) begin
        if (!rst_n)                          xfer_blk_len <= '0;
        else if (cmd_go && load_len)         xfer_blk_len <= arg_q;
        else if (bus_wr && sel == SEL_LEN)   xfer_blk_len <= bus_wdata + 1'b1;
    end

    // Block count: plus-one on software write, forced to one by single-block ops.
    always_ff @(posedge clk) begin
        if (!rst_n)                          xfer_blk_cnt <= '0;
        else if (cmd_go && force_single)     xfer_blk_cnt <= REG_W'(1);
        else if (bus_wr && sel == SEL_CNT)   xfer_blk_cnt <= bus_wdata + 1'b1;
    end

    // Response words: word 0 takes the canned value, the rest clear.
    generate
        for (genvar i = 0; i < RESP_N; i++) begin : g_resp
            always_ff @(posedge clk) begin
                if (!rst_n)      resp_q[i] <= '0;
                else if (cmd_go) resp_q[i] <= (i == 0) ? resp0_c : '0;
            end
        end
    endgenerate

    // Transfer handshake: request raised on a data command, dropped on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_req    <= 1'b0;
            xfer_write  <= 1'b0;
            xfer_offset <= '0;
        end else if (cmd_go && is_data) begin
            xfer_req    <= 1'b1;
            xfer_write  <= is_write;
            xfer_offset <= arg_q;
        end else if (finish) begin
            xfer_req    <= 1'b0;
        end
    end

    // Read mux: only status, responses and state are readable.
    always_comb begin
        case (sel)
            SEL_STATUS: bus_rdata = REG_W'(stat_q & en_q);
            SEL_RESP0:  bus_rdata = resp_q[0];
            SEL_RESP1:  bus_rdata = resp_q[1];
            SEL_RESP2:  bus_rdata = resp_q[2];
            SEL_RESP3:  bus_rdata = resp_q[3];
            SEL_STATE:  bus_rdata = {30'd0, card_ro, 1'b1};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/chr_checker.sv
// Protocol checker for card_host_regs, attached by bind.
module chr_checker
    import card_host_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              card_ro,
    input logic              irq,
    input logic              xfer_req,
    input logic              xfer_write,
    input logic [REG_W-1:0]  xfer_blk_cnt,
    input logic              xfer_done,
    input logic [STAT_W-1:0] stat_q,
    input logic              cmd_go,
    input logic              is_data
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_done |=> xfer_req && $stable(xfer_write) && $stable(xfer_blk_cnt));

    // R10
    done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_done |=> !xfer_req && stat_q[1:0] == 2'b11);

    // R4
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(OFF_ENABLE) && !(xfer_req && xfer_done) |=> stat_q == '0);

    // R7
    eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go && !is_data |=> stat_q[ST_EOC]);

    // R12
    state_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_W'(OFF_STATE) |-> bus_rdata == {30'd0, card_ro, 1'b1});

    // R5
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_W'(OFF_STATUS) && bus_rdata != '0 |=> irq);
endmodule

bind card_host_regs chr_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .card_ro(card_ro), .irq(irq), .xfer_req(xfer_req),
    .xfer_write(xfer_write), .xfer_blk_cnt(xfer_blk_cnt), .xfer_done(xfer_done),
    .stat_q(stat_q), .cmd_go(cmd_go), .is_data(is_data)
);

// File: tb/card_host_regs_tb_top.sv
// Self-checking bench: opcode sweep, offset sweep, status/enable cases.
module card_host_regs_tb_top;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = 8'hFC;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          card_ro = 1'b0;
    logic          irq, xfer_req, xfer_write, xfer_done = 1'b0;
    logic [31:0]   xfer_buf, xfer_offset, xfer_blk_len, xfer_blk_cnt;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    card_host_regs #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_ro(card_ro),
        .irq(irq), .xfer_req(xfer_req), .xfer_write(xfer_write),
        .xfer_buf(xfer_buf), .xfer_offset(xfer_offset),
        .xfer_blk_len(xfer_blk_len), .xfer_blk_cnt(xfer_blk_cnt),
        .xfer_done(xfer_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'hFC;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_addr = 8'hFC;
    endtask

    task automatic pulse_done();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    // Expected canned word 0 from the requirement text.
    function automatic logic [31:0] exp_w0(input int op);
        int st;
        st = -1;
        if (op == 7) st = 3;
        else if (op == 12) st = 5;
        else if (op == 13 || op == 16 || op == 17 || op == 18 || op == 24 || op == 25) st = 4;
        return (st < 0) ? 32'd0 : 32'((st << 9) | 256);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R5, R2, R10)
        chk("R5 reset irq", 32'(irq), 0);
        chk("R10 reset req", 32'(xfer_req), 0);
        rd(8'h00, v); chk("R2 reset status", v, 0);

        // State word (R12)
        rd(8'h2C, v); chk("R12 state ro=0", v, 32'h1);
        card_ro = 1'b1;
        rd(8'h2C, v); chk("R12 state ro=1", v, 32'h3);
        card_ro = 1'b0;

        // Offset sweep: everything but responses and state reads 0 (R1)
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h04, 32'h7);
        for (int a = 0; a < 256; a += 4) begin
            logic [31:0] e;
            e = (a == 8'h2C) ? 32'h1 : 32'h0;
            rd(8'(a), v);
            chk($sformatf("R1 read offset %0h", a), v, e);
        end
        chk("R1 unmapped write no irq", 32'(irq), 0);

        // Plus-one registers and buffer (R6)
        wr(8'h24, 32'd511);
        chk("R6 length plus one", xfer_blk_len, 32'd512);
        wr(8'h28, 32'd3);
        chk("R6 count plus one", xfer_blk_cnt, 32'd4);
        wr(8'h08, 32'hABC0);
        chk("R6 buffer address", xfer_buf, 32'hABC0);

        // Opcode sweep with junk in bits 31:6 (R7, R8, R9, R10, R11, R3)
        for (int op = 0; op < 64; op++) begin
            logic [31:0] argv;
            bit data;
            argv = 32'(op * 16 + 7);
            data = (op == 17 || op == 18 || op == 24 || op == 25);
            wr(8'h10, argv);
            wr(8'h28, 32'd5);
            wr(8'h0C, 32'hFFFF_FFC0 | 32'(op));
            rd(8'h14, v); chk($sformatf("R8 op %0d word0", op), v, exp_w0(op));
            rd(8'h18, v); chk("R7 word1 zero", v, 0);
            rd(8'h20, v); chk("R7 word3 zero", v, 0);
            if (!data) begin
                rd(8'h00, v); chk($sformatf("R7 op %0d eoc", op), v, 32'h1);
                @(negedge clk);
                chk("R5 irq after eoc", 32'(irq), 1);
                if (op == 16) chk("R9 setlen raw arg", xfer_blk_len, argv);
                wr(8'h00, 32'h1);
                rd(8'h00, v); chk("R3 clear eoc", v, 0);
                @(negedge clk);
                chk("R5 irq drops", 32'(irq), 0);
            end else begin
                chk($sformatf("R10 op %0d req", op), 32'(xfer_req), 1);
                chk("R10 write flag", 32'(xfer_write), 32'(op == 24 || op == 25));
                chk("R10 count", xfer_blk_cnt, (op == 17 || op == 24) ? 32'd1 : 32'd6);
                chk("R10 offset", xfer_offset, argv);
                rd(8'h00, v); chk("R10 no flag before done", v, 0);
                wr(8'h0C, 32'd7);
                rd(8'h14, v); chk("R11 busy command ignored", v, 32'h900);
                rd(8'h00, v); chk("R11 busy no eoc", v, 0);
                chk("R11 req held", 32'(xfer_req), 1);
                pulse_done();
                chk("R10 req dropped", 32'(xfer_req), 0);
                rd(8'h00, v); chk("R10 eoc and eod", v, 32'h3);
                wr(8'h00, 32'h1);
                rd(8'h00, v); chk("R3 partial clear", v, 32'h2);
                wr(8'h00, 32'h2);
                rd(8'h00, v); chk("R3 second clear", v, 0);
            end
        end

        // Masking and enable-clears-status (R2, R4, R5)
        wr(8'h04, 32'h1);
        wr(8'h0C, 32'd17);
        pulse_done();
        rd(8'h00, v); chk("R2 masked read", v, 32'h1);
        @(negedge clk);
        chk("R5 irq masked on", 32'(irq), 1);
        wr(8'h04, 32'h6);
        rd(8'h00, v); chk("R4 enable clears", v, 0);
        @(negedge clk);
        chk("R4 irq off after enable", 32'(irq), 0);
        wr(8'h04, 32'h0);
        wr(8'h0C, 32'd13);
        rd(8'h00, v); chk("R2 all masked", v, 0);
        @(negedge clk);
        chk("R5 irq stays low", 32'(irq), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule